// File: doc/BRIEF.md
# Breakpoint and Single-Step Debug Controller

This block sits next to a small 8-bit microcontroller core and decides when the core must leave user code and enter its debug executive. It holds a program-counter breakpoint and three control/status bits in two byte-wide registers on the core's register bus. On every instruction-cycle strobe it compares the fetch address against the breakpoint. It also watches an external halt request and a single-step sequencer. When any of these asks for entry, it raises a one-cycle entry request and captures the fetch address.

While the debug view is active, the block masks interrupts and blocks further entry. When peripheral freeze is enabled, it also asserts a freeze line that timers and serial or converter engines use to stop advancing. A return-from-debug event clears the in-debug flag. The core and the interrupt mask keep seeing "in debug" for four more instruction cycles, so that the executive's return path completes safely. If single-step is enabled at that point, one user instruction runs and then debug is entered again.

The breakpoint and the captured address are cleared only by the power-on reset. The master reset returns the control bits and the sequencing state to idle but keeps both addresses.

Top module: `dbg_break_ctrl`

## Requirements
- R1: After power-on reset, both bus registers read 0x00 and `irq_mask`, `freeze` and `enter_req` are 0.
- R2: Register layout. Select 0 is the control register: bit 7 is the in-debug view, bit 6 is freeze enable, bit 5 is step enable, and bits 4:0 hold address bits 12:8. Select 1 holds address bits 7:0. A write to the address bits sets the breakpoint. A read of them returns the address captured at the last entry, not the written value.
- R3: A fetch address equal to the breakpoint on an `icyc` strobe, while the debug view is 0, enters debug. `enter_req` is high for exactly the one cycle after that strobe edge, and the fetch address is captured at the same edge. Without a strobe, nothing happens.
- R4: A `halt_req` sampled with `icyc` while the debug view is 0 enters debug. While the debug view is 1, halt requests and breakpoint matches cause no entry.
- R5: A breakpoint match and a halt request on the same strobe produce a single one-cycle entry pulse.
- R6: A bus write to control bit 7 has no effect. Only a `dbg_ret` pulse while in debug clears the in-debug flag, and a `dbg_ret` pulse outside debug does nothing.
- R7: After an accepted `dbg_ret`, the debug view stays 1 through the next three `icyc` strobes and falls at the edge of the fourth.
- R8: `irq_mask` equals the debug view: it is 1 from the entry edge until the exit delay of R7 ends.
- R9: `freeze` is 1 exactly when freeze enable is set and the debug view is 1.
- R10: With step enable set when the exit delay ends, the first strobe after that runs one user instruction with no entry. The second strobe enters debug and captures that strobe's address.
- R11: `rst_mclr` clears the flag, the control bits and the sequencers but keeps the breakpoint and the captured address. `rst_por` clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_mclr | input | 1 | Master reset, synchronous, active high |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 address low byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| icyc | input | 1 | Instruction-cycle strobe, one per fetch |
| fetch_pc | input | 13 | Fetch program counter |
| halt_req | input | 1 | External halt request |
| dbg_ret | input | 1 | Return-from-debug event |
| enter_req | output | 1 | One-cycle debug-entry request |
| irq_mask | output | 1 | Interrupt mask (debug view) |
| freeze | output | 1 | Peripheral freeze |

## Verification
A wrong exit counter shows on `irq_mask` and control bit 7 on the very strobe where the view should fall, or should stay up. Breakpoint or capture corruption shows in the `enter_req` pulse timing one cycle after the strobe, or in the address read right after entry. A stuck step sequencer shows as a missing or early entry pulse within two strobes of exit. A reset that clears too much shows at the first matching fetch after a master reset.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int BYTE_W    = 8;
    localparam int HI_FIELD  = 5;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_ADLO = 1'b1;

    localparam int VIEW_BIT  = 7;
    localparam int FRZ_BIT   = 6;
    localparam int STEP_BIT  = 5;

    typedef struct packed {
        logic frz_en;
        logic step_en;
    } dbg_ctrl_t;

    typedef struct packed {
        logic brk;
        logic hlt;
        logic stp;
    } dbg_cause_t;

    function automatic logic any_cause(input dbg_cause_t c);
        return c.brk | c.hlt | c.stp;
    endfunction

endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_pkg::*;
#(
    parameter int PC_W = 13
) (
    input  logic            clk,
    input  logic            rst_por,
    input  logic            rst_mclr,
    input  logic            bus_we,
    input  logic            bus_sel,
    input  logic [7:0]      bus_wdata,
    input  logic            view,
    input  logic            cap_en,
    input  logic [PC_W-1:0] cap_pc,
    output logic [7:0]      bus_rdata,
    output dbg_ctrl_t       ctrl,
    output logic [PC_W-1:0] bp_addr
);
    localparam int HI_W = PC_W - BYTE_W;

    logic [PC_W-1:0]     cap_q;
    logic [HI_FIELD-1:0] hi_pad;
    logic                unused_wbits;

    assign unused_wbits = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (rst_por) begin
            bp_addr <= '0;
            cap_q   <= '0;
        end else begin
            if (cap_en)
                cap_q <= cap_pc;
            if (bus_we) begin
                if (bus_sel == SEL_CTRL)
                    bp_addr[PC_W-1:BYTE_W] <= bus_wdata[HI_W-1:0];
                else
                    bp_addr[BYTE_W-1:0] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_por || rst_mclr) begin
            ctrl <= '0;
        end else if (bus_we && bus_sel == SEL_CTRL) begin
            ctrl.frz_en  <= bus_wdata[FRZ_BIT];
            ctrl.step_en <= bus_wdata[STEP_BIT];
        end
    end

    always_comb begin
        hi_pad = '0;
        hi_pad[HI_W-1:0] = cap_q[PC_W-1:BYTE_W];
        bus_rdata = '0;
        if (bus_sel == SEL_CTRL) begin
            bus_rdata[VIEW_BIT]       = view;
            bus_rdata[FRZ_BIT]        = ctrl.frz_en;
            bus_rdata[STEP_BIT]       = ctrl.step_en;
            bus_rdata[HI_FIELD-1:0]   = hi_pad;
        end else begin
            bus_rdata = cap_q[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/dbg_exit_timer.sv
module dbg_exit_timer #(
    parameter int EXIT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic icyc,
    input  logic ret_accept,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(EXIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(EXIT_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ret_accept)
            cnt <= LOAD;
        else if (icyc && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = icyc && (cnt == CNT_W'(1)) && !ret_accept;

endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq (
    input  logic clk,
    input  logic rst,
    input  logic icyc,
    input  logic view,
    input  logic exit_done,
    input  logic step_en,
    input  logic entry,
    output logic step_due
);
    logic armed;
    logic retired;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            retired <= 1'b0;
        end else if (exit_done) begin
            armed   <= step_en;
            retired <= 1'b0;
        end else if (entry) begin
            armed   <= 1'b0;
            retired <= 1'b0;
        end else if (armed && icyc && !view) begin
            retired <= 1'b1;
        end
    end

    assign step_due = armed && retired && icyc;

endmodule

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl
    import dbg_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int EXIT_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_por,
    input  logic            rst_mclr,
    input  logic            bus_we,
    input  logic            bus_sel,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            icyc,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            halt_req,
    input  logic            dbg_ret,
    output logic            enter_req,
    output logic            irq_mask,
    output logic            freeze
);
    logic            rst_any;
    logic            in_dbg;
    logic            view;
    logic            exit_busy;
    logic            exit_done;
    logic            ret_accept;
    logic            step_due;
    logic            entry;
    dbg_ctrl_t       ctrl;
    dbg_cause_t      cause;
    logic [PC_W-1:0] bp_addr;

    assign rst_any    = rst_por | rst_mclr;
    assign view       = in_dbg | exit_busy;
    assign ret_accept = dbg_ret & in_dbg;

    always_comb begin
        cause.brk = (fetch_pc == bp_addr);
        cause.hlt = halt_req;
        cause.stp = step_due;
    end

    assign entry = icyc & ~view & any_cause(cause);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            in_dbg    <= 1'b0;
            enter_req <= 1'b0;
        end else begin
            enter_req <= entry;
            if (entry)
                in_dbg <= 1'b1;
            else if (ret_accept)
                in_dbg <= 1'b0;
        end
    end

    assign irq_mask = view;
    assign freeze   = view & ctrl.frz_en;

    dbg_regfile #(.PC_W(PC_W)) regs_i (
        .clk       (clk),
        .rst_por   (rst_por),
        .rst_mclr  (rst_mclr),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .view      (view),
        .cap_en    (entry),
        .cap_pc    (fetch_pc),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .bp_addr   (bp_addr)
    );

    dbg_exit_timer #(.EXIT_CYC(EXIT_CYC)) exit_i (
        .clk        (clk),
        .rst        (rst_any),
        .icyc       (icyc),
        .ret_accept (ret_accept),
        .busy       (exit_busy),
        .done       (exit_done)
    );

    dbg_step_seq step_i (
        .clk       (clk),
        .rst       (rst_any),
        .icyc      (icyc),
        .view      (view),
        .exit_done (exit_done),
        .step_en   (ctrl.step_en),
        .entry     (entry),
        .step_due  (step_due)
    );

endmodule

// File: rtl/dbg_break_ctrl_chk.sv
module dbg_break_ctrl_chk (
    input logic clk,
    input logic rst_por,
    input logic rst_mclr,
    input logic icyc,
    input logic dbg_ret,
    input logic enter_req,
    input logic irq_mask,
    input logic freeze,
    input logic in_dbg
);
    // R3: entry request lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        enter_req |=> !enter_req);

    // R4: no entry from a strobe seen while the debug view is up
    a_r4_no_reentry: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        (irq_mask && icyc) |=> !enter_req);

    // R6: flag holds until a return event
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        (in_dbg && !dbg_ret) |=> in_dbg);

    // R7: the view only falls on an instruction strobe
    a_r7_exit_on_strobe: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        (irq_mask && !icyc) |=> irq_mask);

    // R8: masking is up whenever entry is signalled
    a_r8_mask_at_entry: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        enter_req |-> irq_mask);

    // R9: freeze only while the view is up
    a_r9_freeze_in_view: assert property (@(posedge clk) disable iff (rst_por || rst_mclr)
        freeze |-> irq_mask);

endmodule

bind dbg_break_ctrl dbg_break_ctrl_chk chk_i (
    .clk       (clk),
    .rst_por   (rst_por),
    .rst_mclr  (rst_mclr),
    .icyc      (icyc),
    .dbg_ret   (dbg_ret),
    .enter_req (enter_req),
    .irq_mask  (irq_mask),
    .freeze    (freeze),
    .in_dbg    (in_dbg)
);

// File: tb/dbg_break_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_break_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_mclr = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        icyc = 1'b0;
    logic [12:0] fetch_pc = '0;
    logic        halt_req = 1'b0;
    logic        dbg_ret = 1'b0;
    logic        enter_req;
    logic        irq_mask;
    logic        freeze;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbg_break_ctrl dut_i (
        .clk(clk), .rst_por(rst_por), .rst_mclr(rst_mclr),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .icyc(icyc), .fetch_pc(fetch_pc),
        .halt_req(halt_req), .dbg_ret(dbg_ret), .enter_req(enter_req),
        .irq_mask(irq_mask), .freeze(freeze)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ic, input logic [12:0] pc,
                         input logic hr, input logic rt);
        icyc = ic; fetch_pc = pc; halt_req = hr; dbg_ret = rt;
        @(negedge clk);
        icyc = 0; halt_req = 0; dbg_ret = 0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        bus_sel = sel; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        bus_sel = sel;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic set_bp(input logic [12:0] a, input logic frz, input logic stp);
        wr(1'b0, {1'b0, frz, stp, a[12:8]});
        wr(1'b1, a[7:0]);
    endtask

    // expects entry just happened with captured address cap, then leaves debug
    task automatic check_entry(input string req, input logic [12:0] cap, input logic frz);
        logic [7:0] v;
        chk({req, " enter_req"}, enter_req, 1);
        chk("R8 mask at entry", irq_mask, 1);
        chk("R9 freeze at entry", freeze, frz);
        rd(1'b1, v);
        chk({req, " R2 captured low"}, v, cap[7:0]);
        rd(1'b0, v);
        chk({req, " R2 captured high/view"}, v[7:0] & 8'h9F, {1'b1, 2'b00, cap[12:8]});
        @(negedge clk);
        chk("R3 pulse ends", enter_req, 0);
    endtask

    task automatic leave(input logic [12:0] pc, input logic frz);
        drive(0, pc, 0, 1);
        chk("R7 view after return", irq_mask, 1);
        for (int k = 1; k <= 4; k++) begin
            drive(1, pc, 1, 0);
            chk("R7 exit delay", irq_mask, (k < 4) ? 1 : 0);
            chk("R9 freeze follows view", freeze, (k < 4) ? frz : 1'b0);
            chk("R4 no entry in delay", enter_req, 0);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [12:0] bp;
        repeat (3) @(negedge clk);
        rst_por = 0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl reset", v, 0);
        rd(1'b1, v); chk("R1 addr reset", v, 0);
        chk("R1 mask reset", irq_mask, 0);
        chk("R1 freeze reset", freeze, 0);
        chk("R1 enter reset", enter_req, 0);

        // R6 write to bit 7 ignored; R2 address bits read captured value
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R6 R2 ctrl write readback", v, 8'h60);
        chk("R6 mask after write", irq_mask, 0);
        drive(0, 13'h0, 0, 1);
        chk("R6 stray return ignored", irq_mask, 0);

        // R3 breakpoint sweep
        for (int i = 0; i < 24; i++) begin
            logic f;
            bp = (i == 23) ? 13'h1FFF : 13'((i * 1237 + 5) % 8192);
            f = i[0];
            set_bp(bp, f, 1'b0);
            drive(1, bp ^ 13'h0001, 0, 0);
            chk("R3 no match", enter_req, 0);
            drive(0, bp, 0, 0);
            chk("R3 no strobe no entry", enter_req, 0);
            drive(1, bp, 0, 0);
            check_entry("R3", bp, f);
            drive(1, bp, 0, 0);
            chk("R4 match blocked in debug", enter_req, 0);
            leave(bp, f);
        end

        // R4 halt entry and blocking
        set_bp(13'h0F00, 1'b1, 1'b0);
        drive(1, 13'h0042, 1, 0);
        check_entry("R4 halt", 13'h0042, 1'b1);
        drive(1, 13'h0043, 1, 0);
        chk("R4 halt ignored in debug", enter_req, 0);
        wr(1'b0, 8'h00);
        chk("R6 write cannot clear flag", irq_mask, 1);
        wr(1'b0, 8'h4F);
        leave(13'h0044, 1'b1);

        // R5 simultaneous causes
        drive(1, 13'h0F00, 1, 0);
        check_entry("R5", 13'h0F00, 1'b1);
        chk("R5 single pulse", enter_req, 0);
        leave(13'h0050, 1'b1);

        // R10 single step
        set_bp(13'h1000, 1'b0, 1'b1);
        drive(1, 13'h0200, 1, 0);
        check_entry("R10 halt", 13'h0200, 1'b0);
        leave(13'h0201, 1'b0);
        drive(1, 13'h0202, 0, 0);
        chk("R10 first instruction runs", enter_req, 0);
        chk("R10 mask off", irq_mask, 0);
        drive(1, 13'h0203, 0, 0);
        check_entry("R10 step", 13'h0203, 1'b0);
        wr(1'b0, 8'h10);
        leave(13'h0204, 1'b0);
        drive(1, 13'h0205, 0, 0);
        drive(1, 13'h0206, 0, 0);
        chk("R10 free run", enter_req, 0);

        // R11 master reset keeps addresses
        set_bp(13'h0ABC, 1'b1, 1'b0);
        drive(1, 13'h0123, 1, 0);
        check_entry("R11 setup", 13'h0123, 1'b1);
        rst_mclr = 1; @(negedge clk); rst_mclr = 0;
        chk("R11 mclr clears mask", irq_mask, 0);
        rd(1'b0, v); chk("R11 ctrl after mclr", v, 8'h01);
        rd(1'b1, v); chk("R11 capture kept", v, 8'h23);
        drive(1, 13'h0ABC, 0, 0);
        check_entry("R11 bp survives mclr", 13'h0ABC, 1'b0);
        rst_por = 1; @(negedge clk); rst_por = 0;
        rd(1'b0, v); chk("R11 por ctrl", v, 0);
        rd(1'b1, v); chk("R11 por addr", v, 0);
        drive(1, 13'h0000, 0, 0);
        check_entry("R11 bp zero after por", 13'h0000, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule